// File: doc/BRIEF.md
# Memory Dependence Wakeup Unit

This block sits beside an out-of-order issue queue and tracks every in-flight load, store and memory barrier by sequence number and thread. When an operation is inserted it works out whether the operation must wait for an older store or barrier. The producer is taken from a barrier that is in force, or else from a producing-store sequence number that comes in with the insert. The block then holds the operation until both its register operands and its memory ordering are resolved, and emits it on a ready stream that the issue queue consumes.

Stores and barriers wake their waiting dependents. A store does this when it issues or completes, and a barrier does it when it completes. Full and write barriers are tracked separately for loads and for stores, and a barrier stays in force until that same barrier completes. The block also removes wrong-path entries of one thread on a squash and resends rescheduled operations on a replay request. At most one operation leaves per cycle, and the oldest pending one goes first.

Top module: `memdep_wake`

## Requirements
- R1: After reset there is no ready output, the full flag is low and neither barrier is in force.
- R2: The insert kind encoding is 0 load, 1 store, 2 full memory barrier, 3 write barrier. A full barrier makes later loads and stores wait on it. A write barrier makes only later stores wait on it, and loads are unaffected. While a barrier is in force it replaces the predicted producer.
- R3: When the producer number is zero, or no live entry holds that number, the memory dependence is resolved at insert. With registers ready at insert, the operation appears on the ready output one cycle later.
- R4: An operation is sent only when both its register-ready and memory-ready flags are set. Whichever event comes last triggers the send.
- R5: A store that issues or completes, and a barrier that completes, release their dependents. Each dependent with registers ready is sent, and the others only become memory-ready.
- R6: A barrier completion clears a barrier flag only if the recorded number equals the completing number. A newer barrier stays in force.
- R7: A squash of thread T at number N removes every entry of thread T with a larger number, together with its pending replay. Removed entries are never sent later, and other threads are untouched.
- R8: A replay request resends every rescheduled live entry, including one rescheduled in the same cycle.
- R9: An operation inserted as non-speculative is sent only after its explicit non-speculative-ready event. A register-ready event alone does not send it.
- R10: The full flag is high while all 16 slots are occupied. An insert while full is dropped.
- R11: At most one operation is sent per cycle, and the pending one with the smallest sequence number goes first.
- R12: An insert whose producer is released or completed in the same cycle is resolved at once. A register-ready event in the same cycle as its producer's release also sends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Insert an operation |
| ins_kind | input | 2 | Operation kind (R2 encoding) |
| ins_nonspec | input | 1 | Insert without dependence check |
| ins_tid | input | 1 | Thread of inserted operation |
| ins_seq | input | 32 | Sequence number of inserted operation |
| ins_pred | input | 32 | Predicted producing-store number, 0 for none |
| ins_regs_rdy | input | 1 | Registers already ready at insert |
| full_o | output | 1 | All slots occupied |
| rr_valid | input | 1 | Register-ready event |
| rr_seq | input | 32 | Number for register-ready event |
| nsr_valid | input | 1 | Non-speculative ready event |
| nsr_seq | input | 32 | Number for non-speculative ready event |
| iss_valid | input | 1 | Issue event (stores release dependents) |
| iss_seq | input | 32 | Number of issuing operation |
| cmp_valid | input | 1 | Completion of a load or store |
| cmp_seq | input | 32 | Number of completing operation |
| bcmp_valid | input | 1 | Completion of a barrier |
| bcmp_seq | input | 32 | Number of completing barrier |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 1 | Thread to squash |
| sq_seq | input | 32 | Entries with larger numbers are removed |
| rsch_valid | input | 1 | Reschedule an operation for replay |
| rsch_seq | input | 32 | Number of rescheduled operation |
| rpl_valid | input | 1 | Replay all rescheduled operations |
| rdy_valid | output | 1 | A ready operation is presented |
| rdy_seq | output | 32 | Number of ready operation |
| rdy_tid | output | 1 | Thread of ready operation |

## Verification
The hazard of interest is an insert or register-ready event landing in the same cycle as the release of the producer it names. In that case the dependent would otherwise link to a store that has just let go of its dependents and wait forever. The bench drives an insert together with the producer's issue, and separately a register-ready event together with the producer's completion. It judges the result by the dependent appearing on the ready output one cycle later. A second overlap is barrier completion against barrier insertion: a newer write barrier is inserted before the older one completes, and a later store must still be held.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
    parameter int SEQ_W = 32;
    parameter int TID_W = 1;
    parameter int SLOTS = 16;
    localparam int IDX_W = $clog2(SLOTS);

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_MBAR  = 2'd2,
        K_WBAR  = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        op_kind_e         kind;
        logic             regs;
        logic             mem;
        logic             pend;
        logic             rpl;
        logic             pvld;
        logic [IDX_W-1:0] pidx;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] e;
        logic              lb;
        logic [SEQ_W-1:0]  lbs;
        logic              sb;
        logic [SEQ_W-1:0]  sbs;
        logic              rv;
        logic [SEQ_W-1:0]  rseq;
        logic [TID_W-1:0]  rtid;
        logic [IDX_W-1:0]  ridx;
    } state_t;
endpackage

// File: rtl/memdep_cam.sv
module memdep_cam #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int IW = 4
) (
    input  logic [N-1:0]        live,
    input  logic [N-1:0][W-1:0] keys,
    input  logic [W-1:0]        probe,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && live[i] && keys[i] == probe) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_first_free.sv
module memdep_first_free #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  live,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && !live[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_oldest.sv
module memdep_oldest #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int IW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req,
    input  logic [N-1:0][W-1:0] keys,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [W-1:0] best_d;

    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        best_d = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!hit || keys[i] < best_d)) begin
                hit    = 1'b1;
                idx    = IW'(i);
                best_d = keys[i];
            end
        end
    end

    logic older_seen;
    always_comb begin
        older_seen = 1'b0;
        for (int i = 0; i < N; i++)
            if (req[i] && keys[i] < keys[idx]) older_seen = 1'b1;
    end

    p_pick_oldest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req[idx] && !older_seen));
    p_pick_any_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> hit);
endmodule

// File: rtl/memdep_wake.sv
module memdep_wake
    import memdep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [1:0]       ins_kind,
    input  logic             ins_nonspec,
    input  logic [TID_W-1:0] ins_tid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [SEQ_W-1:0] ins_pred,
    input  logic             ins_regs_rdy,
    output logic             full_o,
    input  logic             rr_valid,
    input  logic [SEQ_W-1:0] rr_seq,
    input  logic             nsr_valid,
    input  logic [SEQ_W-1:0] nsr_seq,
    input  logic             iss_valid,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             cmp_valid,
    input  logic [SEQ_W-1:0] cmp_seq,
    input  logic             bcmp_valid,
    input  logic [SEQ_W-1:0] bcmp_seq,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             rsch_valid,
    input  logic [SEQ_W-1:0] rsch_seq,
    input  logic             rpl_valid,
    output logic             rdy_valid,
    output logic [SEQ_W-1:0] rdy_seq,
    output logic [TID_W-1:0] rdy_tid
);
    localparam int Q_RR   = 0;
    localparam int Q_NSR  = 1;
    localparam int Q_ISS  = 2;
    localparam int Q_CMP  = 3;
    localparam int Q_BCMP = 4;
    localparam int Q_RSCH = 5;
    localparam int Q_PROD = 6;
    localparam int NQ     = 7;

    state_t q, d, m;

    // Slot views for the lookup and selection blocks
    logic [SLOTS-1:0]            live_q;
    logic [SLOTS-1:0][SEQ_W-1:0] seq_q;
    logic [SLOTS-1:0]            pend_m;
    logic [SLOTS-1:0][SEQ_W-1:0] seq_m;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            live_q[i] = q.e[i].vld;
            seq_q[i]  = q.e[i].seq;
            pend_m[i] = m.e[i].pend;
            seq_m[i]  = m.e[i].seq;
        end
    end

    // Barrier flags as seen after this cycle's barrier completion
    logic             lb_eff, sb_eff;
    logic [SEQ_W-1:0] prod_seq;
    op_kind_e         kind_in;

    always_comb begin
        kind_in  = op_kind_e'(ins_kind);
        lb_eff   = q.lb && !(bcmp_valid && q.lbs == bcmp_seq);
        sb_eff   = q.sb && !(bcmp_valid && q.sbs == bcmp_seq);
        if (kind_in == K_LOAD && lb_eff)       prod_seq = q.lbs;
        else if (kind_in == K_STORE && sb_eff) prod_seq = q.sbs;
        else                                   prod_seq = ins_pred;
    end

    logic [NQ-1:0][SEQ_W-1:0] probe;
    logic [NQ-1:0]            q_hit;
    logic [NQ-1:0][IDX_W-1:0] q_idx;

    assign probe[Q_RR]   = rr_seq;
    assign probe[Q_NSR]  = nsr_seq;
    assign probe[Q_ISS]  = iss_seq;
    assign probe[Q_CMP]  = cmp_seq;
    assign probe[Q_BCMP] = bcmp_seq;
    assign probe[Q_RSCH] = rsch_seq;
    assign probe[Q_PROD] = prod_seq;

    for (genvar g = 0; g < NQ; g++) begin : g_lookup
        memdep_cam #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_cam (
            .live (live_q),
            .keys (seq_q),
            .probe(probe[g]),
            .hit  (q_hit[g]),
            .idx  (q_idx[g])
        );
    end

    logic             free_hit;
    logic [IDX_W-1:0] free_idx;
    memdep_first_free #(.N(SLOTS), .IW(IDX_W)) u_free (
        .live(live_q), .hit(free_hit), .idx(free_idx)
    );

    // Stage A: apply all events of this cycle
    logic [SLOTS-1:0] wake;
    logic             linked;
    logic [IDX_W-1:0] pi;

    always_comb begin
        m      = q;
        m.rv   = 1'b0;
        wake   = '0;
        linked = 1'b0;
        pi     = q_idx[Q_PROD];

        if (cmp_valid && q_hit[Q_CMP])   wake[q_idx[Q_CMP]]  = 1'b1;
        if (bcmp_valid && q_hit[Q_BCMP]) wake[q_idx[Q_BCMP]] = 1'b1;
        if (iss_valid && q_hit[Q_ISS] && q.e[q_idx[Q_ISS]].kind != K_LOAD)
            wake[q_idx[Q_ISS]] = 1'b1;
        m.lb = lb_eff;
        m.sb = sb_eff;

        for (int j = 0; j < SLOTS; j++) begin
            if (m.e[j].vld && m.e[j].pvld && !m.e[j].mem && wake[m.e[j].pidx]) begin
                m.e[j].mem  = 1'b1;
                m.e[j].pvld = 1'b0;
                if (m.e[j].regs) m.e[j].pend = 1'b1;
            end
        end

        if (cmp_valid && q_hit[Q_CMP])   m.e[q_idx[Q_CMP]]  = '0;
        if (bcmp_valid && q_hit[Q_BCMP]) m.e[q_idx[Q_BCMP]] = '0;

        if (rr_valid && q_hit[Q_RR] && m.e[q_idx[Q_RR]].vld && !m.e[q_idx[Q_RR]].regs) begin
            m.e[q_idx[Q_RR]].regs = 1'b1;
            if (m.e[q_idx[Q_RR]].mem) m.e[q_idx[Q_RR]].pend = 1'b1;
        end

        if (nsr_valid && q_hit[Q_NSR] && m.e[q_idx[Q_NSR]].vld) begin
            m.e[q_idx[Q_NSR]].regs = 1'b1;
            m.e[q_idx[Q_NSR]].mem  = 1'b1;
            m.e[q_idx[Q_NSR]].pend = 1'b1;
        end

        if (sq_valid) begin
            for (int j = 0; j < SLOTS; j++)
                if (m.e[j].vld && m.e[j].tid == sq_tid && m.e[j].seq > sq_seq)
                    m.e[j] = '0;
        end

        if (rsch_valid && q_hit[Q_RSCH] && m.e[q_idx[Q_RSCH]].vld)
            m.e[q_idx[Q_RSCH]].rpl = 1'b1;

        if (rpl_valid) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (m.e[j].vld && m.e[j].rpl) begin
                    m.e[j].pend = 1'b1;
                    m.e[j].rpl  = 1'b0;
                end
            end
        end

        if (ins_valid && free_hit) begin
            m.e[free_idx]      = '0;
            m.e[free_idx].vld  = 1'b1;
            m.e[free_idx].tid  = ins_tid;
            m.e[free_idx].seq  = ins_seq;
            m.e[free_idx].kind = kind_in;
            if (kind_in == K_MBAR) begin
                m.lb  = 1'b1;
                m.lbs = ins_seq;
                m.sb  = 1'b1;
                m.sbs = ins_seq;
            end else if (kind_in == K_WBAR) begin
                m.sb  = 1'b1;
                m.sbs = ins_seq;
            end else if (ins_nonspec) begin
                m.e[free_idx].regs = ins_regs_rdy;
            end else begin
                linked = prod_seq != '0 && q_hit[Q_PROD] && m.e[pi].vld
                         && m.e[pi].seq == prod_seq && !wake[pi];
                m.e[free_idx].regs = ins_regs_rdy;
                m.e[free_idx].mem  = !linked;
                m.e[free_idx].pvld = linked;
                m.e[free_idx].pidx = pi;
                m.e[free_idx].pend = !linked && ins_regs_rdy;
            end
        end
    end

    // Stage B: pick the oldest pending entry for the output register
    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;

    memdep_oldest #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (pend_m),
        .keys (seq_m),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    always_comb begin
        d = m;
        if (pick_hit) begin
            d.e[pick_idx].pend = 1'b0;
            d.rv   = 1'b1;
            d.rseq = m.e[pick_idx].seq;
            d.rtid = m.e[pick_idx].tid;
            d.ridx = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full_o    = &live_q;
    assign rdy_valid = q.rv;
    assign rdy_seq   = q.rseq;
    assign rdy_tid   = q.rtid;

    // Checks
    logic pend_bad;
    always_comb begin
        pend_bad = 1'b0;
        for (int j = 0; j < SLOTS; j++)
            if (q.e[j].pend && !(q.e[j].vld && q.e[j].regs && q.e[j].mem)) pend_bad = 1'b1;
    end

    p_pend_needs_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_bad);
    p_ready_needs_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (q.e[q.ridx].vld && q.e[q.ridx].regs && q.e[q.ridx].mem));
    p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !cmp_valid && !bcmp_valid && !sq_valid) |=> full_o);
    p_store_barrier_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sb && !(bcmp_valid && bcmp_seq == q.sbs)) |=> q.sb);
    p_load_barrier_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lb && !(bcmp_valid && bcmp_seq == q.lbs)) |=> q.lb);
endmodule

// File: tb/memdep_wake_test.sv
`timescale 1ns/1ps
module memdep_wake_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 0, ins_nonspec = 0, ins_regs_rdy = 0;
    logic [1:0]  ins_kind = 0;
    logic [0:0]  ins_tid = 0, sq_tid = 0, rdy_tid;
    logic [31:0] ins_seq = 0, ins_pred = 0, rr_seq = 0, nsr_seq = 0, iss_seq = 0;
    logic [31:0] cmp_seq = 0, bcmp_seq = 0, sq_seq = 0, rsch_seq = 0, rdy_seq;
    logic        rr_valid = 0, nsr_valid = 0, iss_valid = 0, cmp_valid = 0;
    logic        bcmp_valid = 0, sq_valid = 0, rsch_valid = 0, rpl_valid = 0;
    logic        full_o, rdy_valid;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int    exp_seq[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    memdep_wake uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_kind(ins_kind), .ins_nonspec(ins_nonspec),
        .ins_tid(ins_tid), .ins_seq(ins_seq), .ins_pred(ins_pred),
        .ins_regs_rdy(ins_regs_rdy), .full_o(full_o),
        .rr_valid(rr_valid), .rr_seq(rr_seq), .nsr_valid(nsr_valid), .nsr_seq(nsr_seq),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .cmp_valid(cmp_valid), .cmp_seq(cmp_seq),
        .bcmp_valid(bcmp_valid), .bcmp_seq(bcmp_seq), .sq_valid(sq_valid),
        .sq_tid(sq_tid), .sq_seq(sq_seq), .rsch_valid(rsch_valid), .rsch_seq(rsch_seq),
        .rpl_valid(rpl_valid), .rdy_valid(rdy_valid), .rdy_seq(rdy_seq), .rdy_tid(rdy_tid)
    );

    // Monitor: compares every ready output with the scoreboard
    always @(negedge clk) begin
        if (rst_n && rdy_valid) begin
            vectors++;
            if (exp_seq.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected output: actual %0d expected none", rdy_seq);
            end else begin
                if (rdy_seq != 32'(exp_seq[0])) begin
                    fails++;
                    $display("FAIL %s output: actual %0d expected %0d", exp_tag[0], rdy_seq, exp_seq[0]);
                end
                void'(exp_seq.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    task automatic expect_out(int s, string tag);
        exp_seq.push_back(s);
        exp_tag.push_back(tag);
    endtask

    task automatic step();
        @(negedge clk);
        ins_valid = 0; ins_nonspec = 0; rr_valid = 0; nsr_valid = 0; iss_valid = 0;
        cmp_valid = 0; bcmp_valid = 0; sq_valid = 0; rsch_valid = 0; rpl_valid = 0;
    endtask

    task automatic put_ins(int kind, bit ns, int tid, int s, int pred, bit regs);
        ins_valid = 1; ins_kind = 2'(kind); ins_nonspec = ns; ins_tid = 1'(tid);
        ins_seq = 32'(s); ins_pred = 32'(pred); ins_regs_rdy = regs;
    endtask

    task automatic do_ins(int kind, bit ns, int tid, int s, int pred, bit regs);
        put_ins(kind, ns, tid, s, pred, regs);
        step();
    endtask

    task automatic do_cmp(int s);
        cmp_valid = 1; cmp_seq = 32'(s); step();
    endtask

    task automatic settle(string tag);
        repeat (12) step();
        vectors++;
        if (exp_seq.size() != 0) begin
            fails++;
            $display("FAIL %s missing output: actual none expected %0d", tag, exp_seq[0]);
            exp_seq.delete();
            exp_tag.delete();
        end
    endtask

    task automatic check_full(bit e, string tag);
        vectors++;
        if (full_o !== e) begin
            fails++;
            $display("FAIL %s full flag: actual %0b expected %0b", tag, full_o, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        vectors++;
        if (rdy_valid !== 1'b0) begin
            fails++; $display("FAIL R1 ready after reset: actual %0b expected 0", rdy_valid);
        end
        check_full(1'b0, "R1");

        // R10: fill all slots with non-speculative loads
        for (int i = 0; i < 16; i++) do_ins(0, 1, 0, 100 + i, 0, 1);
        check_full(1'b1, "R10");
        do_ins(0, 0, 0, 116, 0, 1);        // dropped: would otherwise be sent (R10)
        settle("R10");
        check_full(1'b1, "R10");
        do_cmp(100);
        check_full(1'b0, "R10");
        for (int i = 1; i < 16; i++) do_cmp(100 + i);

        // R3: store without producer; R5 store issue releases load
        expect_out(10, "R3"); do_ins(1, 0, 0, 10, 0, 1);
        do_ins(0, 0, 0, 11, 10, 1);
        settle("R5");
        expect_out(11, "R5"); iss_valid = 1; iss_seq = 10; step();
        settle("R5");
        // R3: producer number not live
        expect_out(14, "R3"); do_ins(0, 0, 0, 14, 99, 1);
        settle("R3");
        do_cmp(10); do_cmp(11); do_cmp(14);

        // R4/R5: dependent without registers only becomes memory-ready
        expect_out(12, "R4"); do_ins(1, 0, 0, 12, 0, 1);
        do_ins(0, 0, 0, 13, 12, 0);
        iss_valid = 1; iss_seq = 12; step();
        settle("R5");
        expect_out(13, "R4"); rr_valid = 1; rr_seq = 13; step();
        settle("R4");
        do_cmp(12); do_cmp(13);

        // R12: same-cycle insert with producer issue; register-ready with producer completion
        expect_out(15, "R12"); do_ins(1, 0, 0, 15, 0, 1);
        settle("R12");
        expect_out(16, "R12");
        put_ins(0, 0, 0, 16, 15, 1); iss_valid = 1; iss_seq = 15; step();
        do_ins(0, 0, 0, 17, 15, 0);
        settle("R12");
        expect_out(17, "R12");
        cmp_valid = 1; cmp_seq = 15; rr_valid = 1; rr_seq = 17; step();
        settle("R12");
        do_cmp(16); do_cmp(17);

        // R2/R11: full barrier holds load and store; release oldest first
        do_ins(2, 0, 0, 30, 0, 0);
        do_ins(0, 0, 0, 31, 0, 1);
        do_ins(1, 0, 0, 32, 0, 1);
        settle("R2");
        expect_out(31, "R11"); expect_out(32, "R11");
        bcmp_valid = 1; bcmp_seq = 30; step();
        settle("R11");
        do_cmp(31); do_cmp(32);

        // R2/R6: write barrier holds stores only; newer barrier stays in force
        do_ins(3, 0, 0, 40, 0, 0);
        expect_out(41, "R2"); do_ins(0, 0, 0, 41, 0, 1);
        do_ins(1, 0, 0, 42, 0, 1);
        settle("R2");
        do_ins(3, 0, 0, 43, 0, 0);
        expect_out(42, "R6"); bcmp_valid = 1; bcmp_seq = 40; step();
        do_ins(1, 0, 0, 44, 0, 1);
        settle("R6");
        expect_out(44, "R6"); bcmp_valid = 1; bcmp_seq = 43; step();
        settle("R6");
        do_cmp(41); do_cmp(42); do_cmp(44);

        // R7: squash one thread only
        do_ins(1, 0, 0, 50, 0, 0);
        do_ins(0, 0, 1, 51, 50, 1);
        do_ins(0, 0, 0, 52, 50, 1);
        sq_valid = 1; sq_tid = 1; sq_seq = 50; step();
        expect_out(52, "R7"); iss_valid = 1; iss_seq = 50; step();
        settle("R7");
        nsr_valid = 1; nsr_seq = 51; step();   // removed entry must stay silent (R7)
        settle("R7");

        // R8/R11: replay resends all rescheduled entries, oldest first
        rr_valid = 1; rr_seq = 50; step();
        expect_out(50, "R8"); settle("R8");
        rsch_valid = 1; rsch_seq = 52; step();
        settle("R8");
        expect_out(50, "R8"); expect_out(52, "R8");
        rsch_valid = 1; rsch_seq = 50; rpl_valid = 1; step();
        settle("R8");
        // R7: squash drops a queued replay
        rsch_valid = 1; rsch_seq = 52; step();
        sq_valid = 1; sq_tid = 0; sq_seq = 51; step();
        rpl_valid = 1; step();
        settle("R7");
        do_cmp(50);

        // R9: non-speculative waits for its explicit event
        do_ins(0, 1, 0, 70, 0, 1);
        rr_valid = 1; rr_seq = 70; step();
        settle("R9");
        expect_out(70, "R9"); nsr_valid = 1; nsr_seq = 70; step();
        settle("R9");
        do_cmp(70);
        check_full(1'b0, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule